// File: doc/BRIEF.md
# Single-Wire Bus Master Bit Slot Engine

This block is the timing core of a master on an open-drain single-wire bus. It accepts one command at a time: a bus reset with a presence check, a write of one bit, or a read of one bit. It then runs the slot that the command needs. The block only ever pulls the line low through an output-enable. It never drives the line high. After each low phase it releases the line, and it samples the line through a small synchronizer at a fixed point in the slot.

Two timing sets are built in, standard and overdrive. A speed-select input picks one of them when a command is accepted. That set then fixes the low time, the sample point and the total slot length for the whole slot. A parameter gives the number of system clock cycles per microsecond, and every slot time is counted in whole microseconds. The surrounding logic frames bytes and handles protocol commands. It sends a command when `cmd_ready` is high and collects the result on the `done` pulse.

Top module: `owm_master_bit_engine`

## Requirements
- R1: After reset, `busy`, `done`, `bus_oe`, `rd_bit` and `presence` are all 0 and `cmd_ready` is 1.
- R2: A command is accepted on a clock edge where `cmd_valid` is 1 and the block is idle. `busy` is 1 from the next cycle. While busy, `cmd_valid` has no effect and the running slot is not lengthened. `cmd_op` encodes 2'b00 bus reset, 2'b01 write, and 2'b10 or 2'b11 read.
- R3: For a write with `cmd_wbit`=0, `bus_oe` is 1 for 60 µs at standard speed and for 8 µs at overdrive.
- R4: For a write with `cmd_wbit`=1, `bus_oe` is 1 for 6 µs at standard speed and for 1 µs at overdrive.
- R5: A read holds `bus_oe` at 1 for 6 µs (standard) or 1 µs (overdrive). It samples the line 12 µs (standard) or 2 µs (overdrive) after the slot starts, and `rd_bit` takes the sampled level.
- R6: A bus reset holds `bus_oe` at 1 for 480 µs (standard) or 48 µs (overdrive). It samples the line 70 µs (standard) or 8 µs (overdrive) after release. `presence` is 1 when the sampled level is low.
- R7: `busy` lasts 65 µs for writes and reads and 960 µs for a bus reset at standard speed. At overdrive it lasts 10 µs and 96 µs. The line is released for the final part of every slot.
- R8: `done` is a one-cycle pulse in the first idle cycle after each slot, exactly once per command.
- R9: `bus_oe` is 1 from the first cycle of a slot and only during a slot's low phase. It is never 1 while idle.
- R10: `speed_ovd` is latched at acceptance. Changing it during a slot leaves that slot's timing unchanged.
- R11: `rd_bit` changes only through reads and `presence` only through bus resets. Both hold their values while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High when a command can be accepted |
| cmd_op | input | 2 | 00 bus reset, 01 write, 10/11 read |
| cmd_wbit | input | 1 | Bit value for a write |
| speed_ovd | input | 1 | 1 selects overdrive timing, 0 standard |
| busy | output | 1 | Slot in progress |
| done | output | 1 | One-cycle end-of-slot pulse |
| rd_bit | output | 1 | Last bit read from the line |
| presence | output | 1 | Last presence result |
| bus_oe | output | 1 | Pull the line low when 1 |
| bus_in | input | 1 | Level sensed on the line |

## Verification
With T clock cycles per microsecond, a command accepted at edge E sets `busy` and `bus_oe` in the cycle after E. `bus_oe` stays high for exactly low·T cycles. `busy` spans slot·T cycles, and `done` appears in cycle slot·T counted from the cycle after E. The bench samples on falling clock edges and counts the `bus_oe`, `busy` and `done` cycles of each slot. It compares those counts with the microsecond figures above times T. It reads `rd_bit` and `presence` one cycle after `done`, once they have settled. The bench models the slave as pulling the line low in a window around the expected sample point, and the sampled level only comes out right if the sample is taken at that point.

// File: rtl/owm_pkg.sv
package owm_pkg;

    localparam int OWM_US_W = 12;

    typedef enum logic [1:0] {
        OP_BUS_RESET = 2'b00,
        OP_WRITE     = 2'b01,
        OP_READ      = 2'b10,
        OP_READ_ALT  = 2'b11
    } owm_op_e;

    typedef struct packed {
        logic [OWM_US_W-1:0] low_us;
        logic [OWM_US_W-1:0] smp_us;
        logic [OWM_US_W-1:0] end_us;
    } owm_timing_t;

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= 1'b1;
                else        s_q <= d;
            end
            assign q = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] sr_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '1;
                else        sr_q <= {sr_q[STAGES-2:0], d};
            end
            assign q = sr_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/owm_us_timer.sv
module owm_us_timer
    import owm_pkg::*;
#(
    parameter int TICKS_PER_US = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                run,
    output logic [OWM_US_W-1:0] us_cnt,
    output logic                us_first,
    output logic                us_last
);
    logic [OWM_US_W-1:0] us_d, us_q;

    generate
        if (TICKS_PER_US <= 1) begin : g_no_pre
            assign us_first = 1'b1;
            assign us_last  = run;
        end else begin : g_pre
            localparam int PRE_W = $clog2(TICKS_PER_US);
            localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(TICKS_PER_US - 1);
            logic [PRE_W-1:0] pre_d, pre_q;

            always_comb begin
                pre_d = pre_q;
                if (clear)                pre_d = '0;
                else if (run) pre_d = (pre_q == PRE_MAX) ? '0 : pre_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end

            assign us_first = (pre_q == '0);
            assign us_last  = run && (pre_q == PRE_MAX);
        end
    endgenerate

    always_comb begin
        us_d = us_q;
        if (clear)        us_d = '0;
        else if (us_last) us_d = us_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) us_q <= '0;
        else        us_q <= us_d;
    end

    assign us_cnt = us_q;
endmodule

// File: rtl/owm_timing_sel.sv
module owm_timing_sel
    import owm_pkg::*;
#(
    parameter int RST_LOW_STD_US = 480,
    parameter int RST_LOW_OD_US  = 48,
    parameter int PRS_STD_US     = 70,
    parameter int PRS_OD_US      = 8,
    parameter int RST_REL_STD_US = 480,
    parameter int RST_REL_OD_US  = 48,
    parameter int W0_STD_US      = 60,
    parameter int W0_OD_US       = 8,
    parameter int W1_STD_US      = 6,
    parameter int W1_OD_US       = 1,
    parameter int RD_SMP_STD_US  = 12,
    parameter int RD_SMP_OD_US   = 2,
    parameter int REC_STD_US     = 5,
    parameter int REC_OD_US      = 2
) (
    input  owm_op_e     op,
    input  logic        wbit,
    input  logic        ovd,
    output owm_timing_t tim
);
    localparam int W = OWM_US_W;
    localparam logic [W-1:0] RST_LOW_S = W'(RST_LOW_STD_US);
    localparam logic [W-1:0] RST_LOW_O = W'(RST_LOW_OD_US);
    localparam logic [W-1:0] RST_SMP_S = W'(RST_LOW_STD_US + PRS_STD_US);
    localparam logic [W-1:0] RST_SMP_O = W'(RST_LOW_OD_US + PRS_OD_US);
    localparam logic [W-1:0] RST_END_S = W'(RST_LOW_STD_US + RST_REL_STD_US);
    localparam logic [W-1:0] RST_END_O = W'(RST_LOW_OD_US + RST_REL_OD_US);
    localparam logic [W-1:0] W0_S      = W'(W0_STD_US);
    localparam logic [W-1:0] W0_O      = W'(W0_OD_US);
    localparam logic [W-1:0] SHORT_S   = W'(W1_STD_US);
    localparam logic [W-1:0] SHORT_O   = W'(W1_OD_US);
    localparam logic [W-1:0] RD_SMP_S  = W'(RD_SMP_STD_US);
    localparam logic [W-1:0] RD_SMP_O  = W'(RD_SMP_OD_US);
    localparam logic [W-1:0] BIT_END_S = W'(W0_STD_US + REC_STD_US);
    localparam logic [W-1:0] BIT_END_O = W'(W0_OD_US + REC_OD_US);

    always_comb begin
        tim = '0;
        unique case (op)
            OP_BUS_RESET: begin
                tim.low_us = ovd ? RST_LOW_O : RST_LOW_S;
                tim.smp_us = ovd ? RST_SMP_O : RST_SMP_S;
                tim.end_us = ovd ? RST_END_O : RST_END_S;
            end
            OP_WRITE: begin
                if (wbit) tim.low_us = ovd ? SHORT_O : SHORT_S;
                else      tim.low_us = ovd ? W0_O : W0_S;
                tim.smp_us = ovd ? RD_SMP_O : RD_SMP_S;
                tim.end_us = ovd ? BIT_END_O : BIT_END_S;
            end
            default: begin
                tim.low_us = ovd ? SHORT_O : SHORT_S;
                tim.smp_us = ovd ? RD_SMP_O : RD_SMP_S;
                tim.end_us = ovd ? BIT_END_O : BIT_END_S;
            end
        endcase
    end
endmodule

// File: rtl/owm_slot_ctrl.sv
module owm_slot_ctrl
    import owm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic                cmd_wbit,
    input  logic                speed_ovd,
    input  owm_timing_t         tim,
    input  logic [OWM_US_W-1:0] us_cnt,
    input  logic                us_first,
    input  logic                us_last,
    input  logic                line_sync,
    output logic                accept,
    output logic                run,
    output owm_op_e             op_lat,
    output logic                wbit_lat,
    output logic                ovd_lat,
    output logic                done,
    output logic                rd_bit,
    output logic                presence,
    output logic                bus_oe
);
    typedef struct packed {
        logic    run;
        owm_op_e op;
        logic    wbit;
        logic    ovd;
        logic    done;
        logic    rd;
        logic    pres;
    } ctrl_s;

    ctrl_s st_d, st_q;
    logic  at_sample, at_end;

    assign accept    = cmd_valid && !st_q.run;
    assign at_sample = st_q.run && us_first && (us_cnt == tim.smp_us);
    assign at_end    = us_last && (us_cnt == tim.end_us - 1'b1);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.run  = 1'b1;
            st_d.op   = owm_op_e'(cmd_op);
            st_d.wbit = cmd_wbit;
            st_d.ovd  = speed_ovd;
        end else if (st_q.run) begin
            if (at_sample) begin
                unique case (st_q.op)
                    OP_BUS_RESET:          st_d.pres = !line_sync;
                    OP_READ, OP_READ_ALT:  st_d.rd   = line_sync;
                    default:               st_d.rd   = st_q.rd;
                endcase
            end
            if (at_end) begin
                st_d.run  = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.op   <= OP_BUS_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign run      = st_q.run;
    assign op_lat   = st_q.op;
    assign wbit_lat = st_q.wbit;
    assign ovd_lat  = st_q.ovd;
    assign done     = st_q.done;
    assign rd_bit   = st_q.rd;
    assign presence = st_q.pres;
    assign bus_oe   = st_q.run && (us_cnt < tim.low_us);
endmodule

// File: rtl/owm_master_bit_engine.sv
module owm_master_bit_engine
    import owm_pkg::*;
#(
    parameter int TICKS_PER_US   = 8,
    parameter int SYNC_STAGES    = 2,
    parameter int RST_LOW_STD_US = 480,
    parameter int RST_LOW_OD_US  = 48,
    parameter int PRS_STD_US     = 70,
    parameter int PRS_OD_US      = 8,
    parameter int RST_REL_STD_US = 480,
    parameter int RST_REL_OD_US  = 48,
    parameter int W0_STD_US      = 60,
    parameter int W0_OD_US       = 8,
    parameter int W1_STD_US      = 6,
    parameter int W1_OD_US       = 1,
    parameter int RD_SMP_STD_US  = 12,
    parameter int RD_SMP_OD_US   = 2,
    parameter int REC_STD_US     = 5,
    parameter int REC_OD_US      = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [1:0] cmd_op,
    input  logic       cmd_wbit,
    input  logic       speed_ovd,
    output logic       busy,
    output logic       done,
    output logic       rd_bit,
    output logic       presence,
    output logic       bus_oe,
    input  logic       bus_in
);
    owm_timing_t         tim;
    owm_op_e             op_lat;
    logic                wbit_lat, ovd_lat;
    logic                accept, run;
    logic [OWM_US_W-1:0] us_cnt;
    logic                us_first, us_last;
    logic                line_sync;

    owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   (bus_in),
        .q   (line_sync)
    );

    owm_us_timer #(.TICKS_PER_US(TICKS_PER_US)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .run      (run),
        .us_cnt   (us_cnt),
        .us_first (us_first),
        .us_last  (us_last)
    );

    owm_timing_sel #(
        .RST_LOW_STD_US (RST_LOW_STD_US), .RST_LOW_OD_US (RST_LOW_OD_US),
        .PRS_STD_US     (PRS_STD_US),     .PRS_OD_US     (PRS_OD_US),
        .RST_REL_STD_US (RST_REL_STD_US), .RST_REL_OD_US (RST_REL_OD_US),
        .W0_STD_US      (W0_STD_US),      .W0_OD_US      (W0_OD_US),
        .W1_STD_US      (W1_STD_US),      .W1_OD_US      (W1_OD_US),
        .RD_SMP_STD_US  (RD_SMP_STD_US),  .RD_SMP_OD_US  (RD_SMP_OD_US),
        .REC_STD_US     (REC_STD_US),     .REC_OD_US     (REC_OD_US)
    ) u_tsel (
        .op   (op_lat),
        .wbit (wbit_lat),
        .ovd  (ovd_lat),
        .tim  (tim)
    );

    owm_slot_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_wbit  (cmd_wbit),
        .speed_ovd (speed_ovd),
        .tim       (tim),
        .us_cnt    (us_cnt),
        .us_first  (us_first),
        .us_last   (us_last),
        .line_sync (line_sync),
        .accept    (accept),
        .run       (run),
        .op_lat    (op_lat),
        .wbit_lat  (wbit_lat),
        .ovd_lat   (ovd_lat),
        .done      (done),
        .rd_bit    (rd_bit),
        .presence  (presence),
        .bus_oe    (bus_oe)
    );

    assign busy      = run;
    assign cmd_ready = !run;
endmodule

// File: rtl/owm_master_bit_engine_chk.sv
module owm_master_bit_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic bus_oe,
    input logic rd_bit,
    input logic presence
);
    AST_OE_ONLY_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> busy);                                             // R9
    AST_OE_AT_SLOT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> bus_oe);                                      // R9
    AST_ACCEPT_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));                            // R2
    AST_RELEASED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(bus_oe));                              // R7
    AST_DONE_MARKS_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy));                                        // R8
    AST_END_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);                                        // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R8
    AST_RESULTS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ($stable(rd_bit) && $stable(presence)));            // R11
endmodule

bind owm_master_bit_engine owm_master_bit_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .bus_oe    (bus_oe),
    .rd_bit    (rd_bit),
    .presence  (presence)
);

// File: tb/owm_master_bit_engine_bench.sv
module owm_master_bit_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TPU        = 2;
    localparam int WD_LIMIT   = 190000;

    typedef struct packed {
        logic [1:0]  op;
        logic        wbit;
        logic        ovd;
        logic [11:0] lo;
        logic [11:0] hi;
        logic [11:0] low;
        logic [11:0] slot;
        logic        rd;
        logic        pres;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 12'd500, 12'd600, 12'd480, 12'd960, 1'b0, 1'b1},
        '{2'd1, 1'b0, 1'b0, 12'd0,   12'd0,   12'd60,  12'd65,  1'b0, 1'b1},
        '{2'd1, 1'b1, 1'b0, 12'd0,   12'd0,   12'd6,   12'd65,  1'b0, 1'b1},
        '{2'd2, 1'b0, 1'b0, 12'd0,   12'd0,   12'd6,   12'd65,  1'b1, 1'b1},
        '{2'd2, 1'b0, 1'b0, 12'd6,   12'd15,  12'd6,   12'd65,  1'b0, 1'b1},
        '{2'd0, 1'b0, 1'b1, 12'd0,   12'd0,   12'd48,  12'd96,  1'b0, 1'b0},
        '{2'd0, 1'b0, 1'b1, 12'd50,  12'd70,  12'd48,  12'd96,  1'b0, 1'b1},
        '{2'd1, 1'b0, 1'b1, 12'd0,   12'd0,   12'd8,   12'd10,  1'b0, 1'b1},
        '{2'd1, 1'b1, 1'b1, 12'd0,   12'd0,   12'd1,   12'd10,  1'b0, 1'b1},
        '{2'd3, 1'b0, 1'b1, 12'd0,   12'd0,   12'd1,   12'd10,  1'b1, 1'b1},
        '{2'd2, 1'b0, 1'b1, 12'd1,   12'd4,   12'd1,   12'd10,  1'b0, 1'b1},
        '{2'd0, 1'b0, 1'b0, 12'd0,   12'd0,   12'd480, 12'd960, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_op = 2'd0;
    logic       cmd_wbit = 1'b0;
    logic       speed_ovd = 1'b0;
    logic       busy, done, rd_bit, presence, bus_oe, bus_in;
    logic       slave_pull;

    int checks = 0;
    int errors = 0;
    int win_lo = 0;
    int win_hi = 0;
    int t_cyc = 0;
    int busy_tot = 0;
    int oe_tot = 0;
    int done_tot = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    owm_master_bit_engine #(.TICKS_PER_US(TPU)) u_owm_master_bit_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_wbit  (cmd_wbit),
        .speed_ovd (speed_ovd),
        .busy      (busy),
        .done      (done),
        .rd_bit    (rd_bit),
        .presence  (presence),
        .bus_oe    (bus_oe),
        .bus_in    (bus_in)
    );

    always_comb slave_pull = busy && (t_cyc > win_lo * TPU) && (t_cyc <= win_hi * TPU);
    assign bus_in = !(bus_oe || slave_pull);

    always @(negedge clk) begin
        if (busy) t_cyc = t_cyc + 1;
        else      t_cyc = 0;
        if (busy)   busy_tot = busy_tot + 1;
        if (bus_oe) oe_tot   = oe_tot + 1;
        if (done)   done_tot = done_tot + 1;
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > WD_LIMIT) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        checks = checks + 1;
        if (got != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    // flip_at: negedge count at which speed_ovd toggles (0 = never)
    // intr_at: negedge count at which a request is raised during the slot (0 = never)
    task automatic run_cmd(input logic [1:0] op, input logic wb, input logic ovd,
                           input int lo, input int hi, input int flip_at, input int intr_at,
                           output int d_busy, output int d_oe, output int d_done);
        int b0, o0, n0;
        int n;
        win_lo = lo;
        win_hi = hi;
        @(negedge clk);
        b0 = busy_tot; o0 = oe_tot; n0 = done_tot;
        cmd_op = op; cmd_wbit = wb; speed_ovd = ovd; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 1;
        while (!done) begin
            @(negedge clk);
            n = n + 1;
            if (flip_at != 0 && n == flip_at) speed_ovd = !speed_ovd;
            if (intr_at != 0 && n == intr_at) begin
                cmd_valid = 1'b1; cmd_op = 2'd1; cmd_wbit = 1'b0;
            end
            if (intr_at != 0 && n == intr_at + 10) cmd_valid = 1'b0;
        end
        @(negedge clk);
        d_busy = busy_tot - b0;
        d_oe   = oe_tot - o0;
        d_done = done_tot - n0;
        win_lo = 0;
        win_hi = 0;
    endtask

    initial begin
        int db, dl, dd;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 bus_oe", bus_oe, 0);
        check("R1 rd_bit", rd_bit, 0);
        check("R1 presence", presence, 0);
        check("R1 cmd_ready", cmd_ready, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 idle bus_oe", bus_oe, 0);

        // R3 R4 R5 R6 R7 R8 R11: vector table
        for (int i = 0; i < NV; i++) begin
            run_cmd(VECS[i].op, VECS[i].wbit, VECS[i].ovd, int'(VECS[i].lo), int'(VECS[i].hi),
                    0, 0, db, dl, dd);
            $display("vector %0d op %0d ovd %0d", i, VECS[i].op, VECS[i].ovd);
            check("R3/R4/R5/R6 low time", dl, int'(VECS[i].low) * TPU);
            check("R7 slot length", db, int'(VECS[i].slot) * TPU);
            check("R8 done count", dd, 1);
            check("R5/R11 rd_bit", rd_bit, VECS[i].rd);
            check("R6/R11 presence", presence, VECS[i].pres);
        end

        // R2: request during busy is ignored, slot not lengthened
        run_cmd(2'd2, 1'b0, 1'b0, 0, 0, 0, 20, db, dl, dd);
        check("R2 slot length with request while busy", db, 65 * TPU);
        check("R2 low time with request while busy", dl, 6 * TPU);
        check("R5 rd_bit idle line", rd_bit, 1);
        begin
            int b1, o1;
            b1 = busy_tot; o1 = oe_tot;
            repeat (20) @(negedge clk);
            check("R2 no later slot busy", busy_tot - b1, 0);
            check("R2 no later slot drive", oe_tot - o1, 0);
        end

        // R10: speed latched at acceptance
        run_cmd(2'd1, 1'b0, 1'b0, 0, 0, 10, 0, db, dl, dd);
        check("R10 std write0 low after flip", dl, 60 * TPU);
        check("R10 std slot after flip", db, 65 * TPU);
        run_cmd(2'd1, 1'b0, 1'b1, 0, 0, 3, 0, db, dl, dd);
        check("R10 od write0 low after flip", dl, 8 * TPU);
        check("R10 od slot after flip", db, 10 * TPU);
        check("R9 idle after slots", bus_oe, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule